// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the host-visible control state of one bus-master storage DMA channel. The host reaches it through a single-cycle register write port and a registered read port. Through these ports it sets the run and direction controls, watches and acknowledges the channel flags, marks which of the two attached drives may use DMA, and loads the bus address of the descriptor table.

Three single-cycle event pulses come from the channel: transfer complete, error and device interrupt. Two level inputs come from the channel hardware as read-only status bits. The block drives the run, direction and table base outputs of the descriptor-fetch engine. It also provides two decoded outputs. One shows that the channel finished cleanly. The other shows that the hardware reports a still-pending transfer.

Register select codes are 0 for the command register, 1 for the status register and 2 for the table pointer. A read returns its value one clock after the select is presented.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every register reads zero, and `eng_run`, `eng_to_mem`, `tbl_base`, `xfer_ok` and `xfer_pending` are all 0.
- R2: A command write with bit 0 = 1 sets the active flag (status bit 0) and `eng_run` when the stored start bit was 0. Command bit 3 drives `eng_to_mem`: 1 means device-to-memory, 0 means memory-to-device.
- R3: A command write with bit 0 = 0 clears the active flag and `eng_run` on the next clock.
- R4: A `evt_done` or `evt_err` pulse clears the active flag. `evt_err` sets status bit 1 and `evt_irq` sets status bit 2.
- R5: Status bits 1 and 2 are cleared by writing 1 to them, and writing 0 leaves them unchanged. An event that arrives in the same cycle as the clearing write keeps its bit set.
- R6: Status bits 5 and 6 (capability flags for drive 0 and drive 1) read back exactly what was last written to them.
- R7: Status bits 3 and 4 follow `hw_flags[0]` and `hw_flags[1]` and ignore writes. `xfer_pending` is 1 one clock after both flags are high.
- R8: The table pointer always reads with bits 1:0 zero, and it ignores writes while the active flag is set.
- R9: `xfer_ok` is 1 exactly when status bits 2:0 equal 100b (interrupt set, no error, not active).
- R10: A write of start = 1 while the stored start bit is already 1 does not set the active flag. The engine can only be started again after a write of start = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 status, 2 table pointer |
| wr_data | input | PTR_W | Write data (byte registers use bits 7:0) |
| rd_sel | input | 2 | Read target, same coding as `wr_sel` |
| rd_data | output | PTR_W | Registered read data, one clock after `rd_sel` |
| evt_done | input | 1 | Transfer-complete pulse from the channel |
| evt_err | input | 1 | Error pulse from the channel |
| evt_irq | input | 1 | Device interrupt pulse |
| hw_flags | input | 2 | Hardware status levels shown in status bits 4:3 |
| eng_run | output | 1 | Run control to the descriptor-fetch engine |
| eng_to_mem | output | 1 | Direction: 1 device-to-memory |
| tbl_base | output | PTR_W | Descriptor table base address |
| xfer_ok | output | 1 | Clean-completion indication |
| xfer_pending | output | 1 | Both hardware flags high (transfer pending) |

## Verification
Two situations are hard to reach from the ports. The first is an interrupt pulse that lands in the very cycle the host clears that flag. The bench reaches it with a combined drive task that raises `evt_irq` alongside the status write, and expects the bit to survive. The second is a restart write that comes after a completion while the stored start bit is still 1. The bench replays the command value after `evt_done` and expects the channel to stay idle until start has been written 0 and then 1 again.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PTR  = 2'd2
  } bm_sel_e;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
endpackage

// File: rtl/bm_cmd_reg.sv
module bm_cmd_reg
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic [7:0] wdata,
  input  logic       evt_done,
  input  logic       evt_err,
  output logic       act_q,
  output logic       dir_q,
  output logic       start_q
);
  logic go_set, go_clr;

  assign go_set = cmd_we && wdata[CMD_GO] && !start_q;
  assign go_clr = (cmd_we && !wdata[CMD_GO]) || evt_done || evt_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (cmd_we) begin
        start_q <= wdata[CMD_GO];
        dir_q   <= wdata[CMD_DIR];
      end
      if (go_clr)      act_q <= 1'b0;
      else if (go_set) act_q <= 1'b1;
    end
  end

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wdata[CMD_GO] && !start_q && !evt_done && !evt_err) |=> act_q);
  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !wdata[CMD_GO]) |=> !act_q);
  assert_event_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_done || evt_err) |=> !act_q);
  assert_no_rearm_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && start_q && !act_q) |=> !act_q);
endmodule

// File: rtl/bm_stat_reg.sv
module bm_stat_reg
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       st_we,
  input  logic [7:0] wdata,
  input  logic       evt_err,
  input  logic       evt_irq,
  output logic       err_q,
  output logic       irq_q,
  output logic [1:0] cap_q
);
  logic ack_err, ack_irq;

  assign ack_err = st_we && wdata[ST_ERR];
  assign ack_irq = st_we && wdata[ST_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      err_q <= evt_err || (err_q && !ack_err);
      irq_q <= evt_irq || (irq_q && !ack_irq);
      if (st_we) cap_q <= {wdata[ST_CAP1], wdata[ST_CAP0]};
    end
  end

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    evt_err |=> err_q);
  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    evt_irq |=> irq_q);
  assert_cap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !st_we |=> $stable(cap_q));
endmodule

// File: rtl/bm_ptr_reg.sv
module bm_ptr_reg #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_we,
  input  logic             lock,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int HI_W = PTR_W - ALIGN_BITS;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst)                  hi_q <= '0;
    else if (ptr_we && !lock) hi_q <= wdata[PTR_W-1:ALIGN_BITS];
  end

  assign ptr_q = {hi_q, {ALIGN_BITS{1'b0}}};

  assert_locked_R8: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(ptr_q));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [PTR_W-1:0] rd_data,
  input  logic             evt_done,
  input  logic             evt_err,
  input  logic             evt_irq,
  input  logic [1:0]       hw_flags,
  output logic             eng_run,
  output logic             eng_to_mem,
  output logic [PTR_W-1:0] tbl_base,
  output logic             xfer_ok,
  output logic             xfer_pending
);
  localparam int PAD_W = PTR_W - 8;

  logic act_q, dir_q, start_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic [7:0] cmd_byte, stat_byte;
  logic [PTR_W-1:0] ptr_q;

  bm_cmd_reg u_cmd (
    .clk(clk), .rst(rst),
    .cmd_we(wr_en && wr_sel == SEL_CMD), .wdata(wr_data[7:0]),
    .evt_done(evt_done), .evt_err(evt_err),
    .act_q(act_q), .dir_q(dir_q), .start_q(start_q)
  );

  bm_stat_reg u_stat (
    .clk(clk), .rst(rst),
    .st_we(wr_en && wr_sel == SEL_STAT), .wdata(wr_data[7:0]),
    .evt_err(evt_err), .evt_irq(evt_irq),
    .err_q(err_q), .irq_q(irq_q), .cap_q(cap_q)
  );

  bm_ptr_reg #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk(clk), .rst(rst),
    .ptr_we(wr_en && wr_sel == SEL_PTR), .lock(act_q),
    .wdata(wr_data), .ptr_q(ptr_q)
  );

  assign cmd_byte  = {4'b0, dir_q, 2'b0, start_q};
  assign stat_byte = {1'b0, cap_q, hw_flags, irq_q, err_q, act_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      xfer_pending <= 1'b0;
    end else begin
      xfer_pending <= &hw_flags;
      case (bm_sel_e'(rd_sel))
        SEL_CMD:  rd_data <= {{PAD_W{1'b0}}, cmd_byte};
        SEL_STAT: rd_data <= {{PAD_W{1'b0}}, stat_byte};
        SEL_PTR:  rd_data <= ptr_q;
        default:  rd_data <= '0;
      endcase
    end
  end

  assign eng_run    = act_q;
  assign eng_to_mem = dir_q;
  assign tbl_base   = ptr_q;
  assign xfer_ok    = irq_q && !err_q && !act_q;

  assert_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (&hw_flags) |=> xfer_pending);
  assert_ok_excl_R9: assert property (@(posedge clk) disable iff (rst)
    evt_err |=> !xfer_ok);
endmodule

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
  localparam int PTR_W = 32;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0, hw_flags = 0;
  logic [PTR_W-1:0] wr_data = 0, rd_data, tbl_base;
  logic evt_done = 0, evt_err = 0, evt_irq = 0;
  logic eng_run, eng_to_mem, xfer_ok, xfer_pending;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  bmdma_regs #(.PTR_W(PTR_W)) i_bmdma_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_done(evt_done), .evt_err(evt_err),
    .evt_irq(evt_irq), .hw_flags(hw_flags), .eng_run(eng_run),
    .eng_to_mem(eng_to_mem), .tbl_base(tbl_base), .xfer_ok(xfer_ok),
    .xfer_pending(xfer_pending)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic drive(logic we, logic [1:0] sel, logic [31:0] d,
                       logic dn, logic er, logic iq);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d;
    evt_done = dn; evt_err = er; evt_irq = iq;
    @(negedge clk);
    wr_en = 0; evt_done = 0; evt_err = 0; evt_irq = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    drive(1, sel, d, 0, 0, 0);
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 cmd", v, 0);
    rd(1, v); chk("R1 stat", v, 0);
    rd(2, v); chk("R1 ptr", v, 0);
    chk("R1 outs", {eng_run, eng_to_mem, xfer_ok, xfer_pending}, 0);
    chk("R1 tbl", tbl_base, 0);
  endtask

  task automatic t_ptr_start;
    logic [31:0] v;
    wr(2, 32'h12345677);
    chk("R8 align", tbl_base, 32'h12345674);
    wr(0, 32'h09);
    chk("R2 run", eng_run, 1);
    chk("R2 dir", eng_to_mem, 1);
    rd(1, v); chk("R2 stat act", v, 32'h01);
    wr(2, 32'hAAAA0000);
    chk("R8 locked", tbl_base, 32'h12345674);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(0, 32'h09);
    chk("R10 still active", eng_run, 1);
    drive(0, 0, 0, 1, 0, 0);
    chk("R4 done clears", eng_run, 0);
    wr(0, 32'h09);
    rd(1, v); chk("R10 no rearm", v, 32'h00);
    wr(0, 32'h08);
    wr(0, 32'h01);
    chk("R2 rearm", eng_run, 1);
    chk("R2 dir mem-to-dev", eng_to_mem, 0);
    wr(0, 32'h00);
    chk("R3 stop", eng_run, 0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    drive(0, 0, 0, 0, 0, 1);
    rd(1, v); chk("R4 irq set", v, 32'h04);
    chk("R9 ok clean", xfer_ok, 1);
    wr(0, 32'h01);
    chk("R9 ok while active", xfer_ok, 0);
    drive(0, 0, 0, 0, 1, 0);
    rd(1, v); chk("R4 err clears act", v, 32'h06);
    chk("R9 ok with err", xfer_ok, 0);
    wr(0, 32'h00);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(1, 32'h02);
    rd(1, v); chk("R5 err cleared", v, 32'h04);
    wr(1, 32'h00);
    rd(1, v); chk("R5 zero no effect", v, 32'h04);
    drive(1, 1, 32'h06, 0, 0, 1);
    rd(1, v); chk("R5 set beats clear", v, 32'h04);
    wr(1, 32'h06);
    rd(1, v); chk("R5 both cleared", v, 32'h00);
  endtask

  task automatic t_cap_hw;
    logic [31:0] v;
    wr(1, 32'h60);
    rd(1, v); chk("R6 both caps", v, 32'h60);
    wr(1, 32'h3E);
    rd(1, v); chk("R6 cap0 only, R7 ro bits", v, 32'h20);
    hw_flags = 2'b01;
    rd(1, v); chk("R7 flag3", v, 32'h28);
    chk("R7 not pending", xfer_pending, 0);
    hw_flags = 2'b11;
    rd(1, v); chk("R7 both flags", v, 32'h38);
    chk("R7 pending", xfer_pending, 1);
    hw_flags = 2'b00;
    @(negedge clk);
    @(negedge clk);
    chk("R7 pending drops", xfer_pending, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_ptr_start;
    t_restart;
    t_events;
    t_w1c;
    t_cap_hw;
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule